// File: doc/BRIEF.md
# Addressed Switch-State Latch

This block holds the per-pixel control word for a video digitizer channel pair. A timing controller broadcasts write strobes to all video boards on a shared bus. Each strobe carries a four-bit timing address and a data word. The latch takes the word only when the address equals the value set by the board's own group of four timing jumpers. With 16 possible addresses, several boards can share one bus and either follow the same timing or follow different timing.

The stored word drives analog switch controls and four converter control lines: start-conversion and transfer for channel A, and start-conversion and transfer for channel B. Downstream logic acts on the low-to-high transition of each of these four lines. For this reason the latch also emits a registered one-cycle pulse on every rising edge of each line. Some positions of the word have no function. They are forced to zero, so no write can set them. Reset clears the whole word, so power-up produces no false start or transfer edge.

Top module: `swl_latch`

## Requirements
- R1: While `rst` is high at a clock edge, `sw_state` and `ctl_rise` become all zeros on that edge.
- R2: A write is accepted when `wr_stb` is high and `wr_addr` equals `jumper_addr`. At the next clock edge `sw_state` takes `wr_data` with the ignored positions cleared.
- R3: A strobe whose `wr_addr` differs from `jumper_addr` leaves `sw_state` unchanged.
- R4: When `wr_stb` is low, `sw_state` does not change, whatever values `wr_addr` and `wr_data` carry.
- R5: Word positions 2, 3, 6 and 7 (ignore mask 0x0CC for a 12-bit word) always read 0 on `sw_state`, even when a write carries ones there.
- R6: `start_a`, `xfer_a`, `start_b` and `xfer_b` equal `sw_state` bits 0, 1, 4 and 5 respectively.
- R7: `ctl_rise` bit k (0 start_a, 1 xfer_a, 2 start_b, 3 xfer_b) is high for exactly the cycle in which that line first shows 1 after showing 0. It stays low when a write keeps the line at 1 or clears it.
- R8: Accepted writes on consecutive clock cycles each take effect, one after the other, with no cycle lost.
- R9: `jumper_addr` is compared as read from the jumpers (an installed jumper reads as 0). When the jumper value changes, the accepted address changes with it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_stb | input | 1 | Switch-state write strobe from the timing bus |
| wr_addr | input | 4 | Timing address carried with the strobe |
| wr_data | input | 12 | Switch-state word carried with the strobe |
| jumper_addr | input | 4 | Timing jumper read value (installed = 0) |
| sw_state | output | 12 | Latched switch-state word |
| start_a | output | 1 | Start-conversion line, channel A |
| xfer_a | output | 1 | Transfer line, channel A |
| start_b | output | 1 | Start-conversion line, channel B |
| xfer_b | output | 1 | Transfer line, channel B |
| ctl_rise | output | 4 | One-cycle rising-edge pulses of the four control lines |

## Verification
The state update and the edge pulse come from the same accepted write. A single write can therefore raise one control line, hold a second line high and drop a third, all in the same cycle. The bench provokes this by sending back-to-back writes whose words overlap in different ways on the four control positions. A behavioural model works out the expected word and the expected pulses from the previous word the model holds itself. The bench compares the model and the outputs on every cycle, so a pulse that is late, repeated or missing is reported in the cycle where it goes wrong.

// File: rtl/swl_pkg.sv
package swl_pkg;
  localparam int unsigned NUM_STROBE = 4;
  // Index order: 0 start_a, 1 xfer_a, 2 start_b, 3 xfer_b
  localparam int unsigned STROBE_POS [NUM_STROBE] = '{0, 1, 4, 5};
  localparam int unsigned IDX_START_A = 0;
  localparam int unsigned IDX_XFER_A  = 1;
  localparam int unsigned IDX_START_B = 2;
  localparam int unsigned IDX_XFER_B  = 3;
endpackage

// File: rtl/swl_addr_match.sv
module swl_addr_match #(
  parameter int unsigned ADDR_W = 4
) (
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [ADDR_W-1:0] own_addr,
  output logic              hit
);
  always_comb hit = (bus_addr == own_addr);
endmodule

// File: rtl/swl_state_reg.sv
module swl_state_reg #(
  parameter int unsigned   DATA_W      = 12,
  parameter logic [DATA_W-1:0] IGNORE_MASK = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [DATA_W-1:0] d,
  output logic [DATA_W-1:0] q
);
  localparam logic [DATA_W-1:0] KEEP = ~IGNORE_MASK;

  always_ff @(posedge clk) begin
    if (rst)       q <= '0;
    else if (load) q <= d & KEEP;
  end
endmodule

// File: rtl/swl_edge_gen.sv
module swl_edge_gen #(
  parameter int unsigned N = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [N-1:0] cur,
  input  logic [N-1:0] nxt,
  output logic [N-1:0] pulse
);
  always_ff @(posedge clk) begin
    if (rst)       pulse <= '0;
    else if (load) pulse <= nxt & ~cur;
    else           pulse <= '0;
  end
endmodule

// File: rtl/swl_latch.sv
module swl_latch
  import swl_pkg::*;
#(
  parameter int unsigned       DATA_W      = 12,
  parameter int unsigned       ADDR_W      = 4,
  parameter logic [DATA_W-1:0] IGNORE_MASK = 12'h0CC
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_stb,
  input  logic [ADDR_W-1:0]     wr_addr,
  input  logic [DATA_W-1:0]     wr_data,
  input  logic [ADDR_W-1:0]     jumper_addr,
  output logic [DATA_W-1:0]     sw_state,
  output logic                  start_a,
  output logic                  xfer_a,
  output logic                  start_b,
  output logic                  xfer_b,
  output logic [NUM_STROBE-1:0] ctl_rise
);
  logic                  hit;
  logic                  load;
  logic [DATA_W-1:0]     data_kept;
  logic [NUM_STROBE-1:0] strb_cur;
  logic [NUM_STROBE-1:0] strb_nxt;

  swl_addr_match #(.ADDR_W(ADDR_W)) u_match (
    .bus_addr (wr_addr),
    .own_addr (jumper_addr),
    .hit      (hit)
  );

  always_comb begin
    load      = wr_stb & hit;
    data_kept = wr_data & ~IGNORE_MASK;
  end

  swl_state_reg #(.DATA_W(DATA_W), .IGNORE_MASK(IGNORE_MASK)) u_state (
    .clk  (clk),
    .rst  (rst),
    .load (load),
    .d    (wr_data),
    .q    (sw_state)
  );

  for (genvar k = 0; k < NUM_STROBE; k++) begin : g_pick
    assign strb_cur[k] = sw_state[STROBE_POS[k]];
    assign strb_nxt[k] = data_kept[STROBE_POS[k]];
  end

  swl_edge_gen #(.N(NUM_STROBE)) u_edge (
    .clk   (clk),
    .rst   (rst),
    .load  (load),
    .cur   (strb_cur),
    .nxt   (strb_nxt),
    .pulse (ctl_rise)
  );

  always_comb begin
    start_a = strb_cur[IDX_START_A];
    xfer_a  = strb_cur[IDX_XFER_A];
    start_b = strb_cur[IDX_START_B];
    xfer_b  = strb_cur[IDX_XFER_B];
  end
endmodule

// File: rtl/swl_latch_chk.sv
module swl_latch_chk #(
  parameter int unsigned       DATA_W      = 12,
  parameter int unsigned       ADDR_W      = 4,
  parameter logic [DATA_W-1:0] IGNORE_MASK = 12'h0CC
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_stb,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic [ADDR_W-1:0] jumper_addr,
  input logic [DATA_W-1:0] sw_state,
  input logic              start_a,
  input logic              xfer_a,
  input logic              start_b,
  input logic              xfer_b,
  input logic [3:0]        ctl_rise
);
  assert_reset_R1: assert property (@(posedge clk)
    rst |=> (sw_state == '0 && ctl_rise == '0));

  assert_load_R2: assert property (@(posedge clk) disable iff (rst)
    (wr_stb && wr_addr == jumper_addr) |=> sw_state == ($past(wr_data) & ~IGNORE_MASK));

  assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
    !(wr_stb && wr_addr == jumper_addr) |=> $stable(sw_state));

  assert_ignored_R5: assert property (@(posedge clk) disable iff (rst)
    (sw_state & IGNORE_MASK) == '0);

  assert_rise_R7: assert property (@(posedge clk) disable iff (rst)
    ctl_rise == {$rose(xfer_b), $rose(start_b), $rose(xfer_a), $rose(start_a)});
endmodule

bind swl_latch swl_latch_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .IGNORE_MASK(IGNORE_MASK)
) u_chk (
  .clk(clk), .rst(rst), .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
  .jumper_addr(jumper_addr), .sw_state(sw_state), .start_a(start_a),
  .xfer_a(xfer_a), .start_b(start_b), .xfer_b(xfer_b), .ctl_rise(ctl_rise)
);

// File: tb/test_swl_latch.sv
module test_swl_latch;
  localparam logic [11:0] IGN = 12'h0CC;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_stb = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [11:0] wr_data = '0;
  logic [3:0]  jumper_addr = 4'h5;
  logic [11:0] sw_state;
  logic        start_a, xfer_a, start_b, xfer_b;
  logic [3:0]  ctl_rise;

  int    n_cmp = 0;
  int    n_bad = 0;
  bit    done = 0;
  string tag = "R1";

  logic [11:0] m_st = '0;
  logic [3:0]  m_rise = '0;
  bit          m_valid = 0;

  always #2 clk = ~clk;

  swl_latch i_swl_latch (
    .clk(clk), .rst(rst), .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
    .jumper_addr(jumper_addr), .sw_state(sw_state), .start_a(start_a),
    .xfer_a(xfer_a), .start_b(start_b), .xfer_b(xfer_b), .ctl_rise(ctl_rise)
  );

  function automatic logic [3:0] lines(input logic [11:0] w);
    return {w[5], w[4], w[1], w[0]};
  endfunction

  // Behavioural reference model
  always @(posedge clk) begin
    logic [11:0] nw;
    if (rst) begin
      m_st = '0; m_rise = '0;
    end else if (wr_stb && wr_addr == jumper_addr) begin
      nw = wr_data & ~IGN;
      m_rise = lines(nw) & ~lines(m_st);
      m_st = nw;
    end else begin
      m_rise = '0;
    end
    m_valid = 1;
  end

  task automatic cmp(input string req, input logic [11:0] act, input logic [11:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s at %0t: actual %h expected %h", req, $time, act, exp);
    end
  endtask

  always @(negedge clk) if (m_valid && !done) begin
    cmp(tag, sw_state, m_st);
    cmp("R5", sw_state & IGN, 12'h000);
    cmp("R6", {8'h00, xfer_b, start_b, xfer_a, start_a}, {8'h00, lines(sw_state)});
    cmp("R7", {8'h00, ctl_rise}, {8'h00, m_rise});
  end

  task automatic put(input logic s, input logic [3:0] a, input logic [11:0] d);
    @(negedge clk);
    wr_stb = s; wr_addr = a; wr_data = d;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) put(1'b0, 4'h0, 12'h000);
  endtask

  task automatic finish_run;
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(4 * 200000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    tag = "R1";
    put(1'b1, 4'h5, 12'hFFF);     // strobe during reset must not load
    idle(2);
    @(negedge clk); rst = 0;
    tag = "R2";
    put(1'b1, 4'h5, 12'hA31);
    put(1'b1, 4'h5, 12'h512);
    idle(2);
    tag = "R3";
    for (int a = 0; a < 16; a++) if (a != 5) put(1'b1, 4'(a), 12'hFFF);
    idle(1);
    tag = "R4";
    put(1'b0, 4'h5, 12'h000);
    put(1'b0, 4'h5, 12'hFFF);
    idle(1);
    tag = "R5";
    put(1'b1, 4'h5, 12'hFFF);
    put(1'b1, 4'h5, 12'h0CC);
    idle(1);
    tag = "R7";
    put(1'b1, 4'h5, 12'h001);     // start_a rises
    put(1'b1, 4'h5, 12'h003);     // start_a held, xfer_a rises
    put(1'b1, 4'h5, 12'h032);     // start_a falls, start_b/xfer_b rise
    put(1'b1, 4'h5, 12'h032);     // unchanged, no pulse
    put(1'b1, 4'h5, 12'h000);
    idle(1);
    tag = "R8";
    for (int i = 0; i < 24; i++) put(1'b1, 4'h5, 12'((i * 37) ^ (i << 4)));
    idle(1);
    tag = "R9";
    @(negedge clk); jumper_addr = 4'h0;
    put(1'b1, 4'h5, 12'h333);     // old address now ignored
    put(1'b1, 4'h0, 12'h123);
    @(negedge clk); jumper_addr = 4'hF;
    put(1'b1, 4'h0, 12'hFFF);
    put(1'b1, 4'hF, 12'h811);
    idle(2);
    tag = "R1";
    @(negedge clk); rst = 1;
    idle(2);
    @(negedge clk); rst = 0;
    idle(2);
    finish_run();
  end
endmodule